// File: doc/BRIEF.md
# EDO DRAM Device-Side Cycle Model

This block is a synthesizable stand-in for an asynchronous 16-bit extended-data-out DRAM. It is used where a controller design needs a real memory partner in a clocked fabric. It samples the row strobe, the two column strobes (one per byte lane), the write strobe, the output enable and the multiplexed address on a fast system clock. It does not decode fixed command values. It works out what kind of cycle is taking place from the order in which the strobe edges arrive.

A row strobe fall with both column strobes high opens an access and captures the row. Each column strobe fall after that captures a column, and then either reads the addressed byte or writes it. A column strobe that is already low when the row strobe falls marks a self-addressed refresh, which uses an internal wrapping row counter. A row strobe pulse with no column activity refreshes the captured row. When the write strobe falls late within a read, the old data is replaced (read-modify-write). A write strobe fall that lands too soon after the column fall to count as a read-modify-write is flagged as indeterminate. Read data stays on the bus past the column strobe rise, as in extended-data-out operation. Refresh events are reported on a strobe together with the row they touched.

Top module: `edo_dram_model`

## Requirements
- R1: After a synchronous reset the model shows no lane drive, no refresh strobe, no indeterminate flag and no sequence error, and its refresh counter is 0.
- R2: A row strobe fall with both column strobes high captures `addr` as the row. A later column strobe fall with `wr_n` high reads the byte stored at (row, `addr`) for each lane whose strobe fell. The byte appears on `dout` with its `dout_en` bit set one clock after the fall is sampled. Lane 0 is `din`/`dout` bits 7:0 with `col_stb_n[0]`, and lane 1 is bits 15:8 with `col_stb_n[1]`.
- R3: When `wr_n` is low at a column strobe fall, `din` is written for the lanes whose strobe fell, and those lanes do not drive.
- R4: When `wr_n` falls RMW_MIN (default 2) or more samples after the last column strobe fall, with the row strobe and at least one column strobe still low, `din` is written at the most recently captured column for every lane whose strobe is low. Up to that point the lane drives the old data.
- R5: When `wr_n` falls 1 to RMW_MIN-1 samples after a column fall, nothing is written and `wr_indet` rises. It stays high until the next row strobe fall.
- R6: A row strobe fall with either column strobe low and `wr_n` high pulses `rfsh_stb` for one clock with `rfsh_auto`=1 and `rfsh_row` equal to the counter. The counter then steps by one and wraps from 511 to 0.
- R7: A row strobe rise that closes an access with no column strobe fall pulses `rfsh_stb` with `rfsh_auto`=0 and `rfsh_row` equal to the captured row.
- R8: A lane keeps driving after its column strobe rises. Driving stops only when the row strobe and both column strobes are high, or when `wr_n` falls.
- R9: `dout_en` is the registered lane drive gated by `out_en_n` sampled low.
- R10: If the column strobes stay low after a read while the row strobe rises and falls again, a self-addressed refresh takes place and the read data keeps driving.
- R11: A row strobe fall with a column strobe low and `wr_n` low pulses `seq_err` for one clock. No refresh takes place and the counter is unchanged.
- R12: Several column strobe falls within one row strobe low period each access their own column in that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | LANES | Column strobe per byte lane, active low |
| wr_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | LANES | Per-lane drive enable |
| rfsh_stb | output | 1 | One-clock refresh event strobe |
| rfsh_auto | output | 1 | Refresh used the internal counter |
| rfsh_row | output | REF_W | Row refreshed |
| wr_indet | output | 1 | Write strobe timing fitted no defined cycle |
| seq_err | output | 1 | Strobe ordering violation |

## Verification
The bench probes the boundary between read-modify-write and the indeterminate case, one sample apart. A design that gets the window wrong either corrupts memory on a mistimed strobe or drops a valid read-modify-write. It runs more than 512 self-addressed refreshes, so a counter that fails to wrap or steps on a rejected cycle shows up as a wrong reported row. Hidden refresh and a column strobe rise during a read catch a design that turns its output off on the wrong edge. An access with output enable high catches a design that ignores the gate. Page-mode reads and byte-lane writes expose column capture that is stale or ignores the lanes.

// File: rtl/edo_dram_pkg.sv
package edo_dram_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACCESS  = 2'd1,
    PH_REFRESH = 2'd2,
    PH_REJECT  = 2'd3
  } phase_t;
endpackage

// File: rtl/edo_pin_edges.sv
module edo_pin_edges #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_stb_n,
  input  logic [LANES-1:0] col_stb_n,
  input  logic             wr_n,
  output logic             row_fall,
  output logic             row_rise,
  output logic [LANES-1:0] col_fall,
  output logic             wr_fall
);
  logic             row_q;
  logic [LANES-1:0] col_q;
  logic             wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= 1'b1;
      col_q <= '1;
      wr_q  <= 1'b1;
    end else begin
      row_q <= row_stb_n;
      col_q <= col_stb_n;
      wr_q  <= wr_n;
    end
  end

  assign row_fall = row_q & ~row_stb_n;
  assign row_rise = ~row_q & row_stb_n;
  assign col_fall = col_q & ~col_stb_n;
  assign wr_fall  = wr_q & ~wr_n;
endmodule

// File: rtl/edo_rfsh_ctr.sv
module edo_rfsh_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/edo_lane_store.sv
module edo_lane_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wen,
  input  logic          ren,
  input  logic [AW-1:0] adr,
  input  logic [DW-1:0] wdat,
  output logic [DW-1:0] rdat
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wen) cells[adr] <= wdat;
    if (ren) rdat <= cells[adr];
  end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
  import edo_dram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int REF_W   = 9,
  parameter int RMW_MIN = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      row_stb_n,
  input  logic [LANES-1:0]          col_stb_n,
  input  logic                      wr_n,
  input  logic                      out_en_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic [LANES-1:0]          dout_en,
  output logic                      rfsh_stb,
  output logic                      rfsh_auto,
  output logic [REF_W-1:0]          rfsh_row,
  output logic                      wr_indet,
  output logic                      seq_err
);
  localparam int MA_W  = 2 * ADDR_W;
  localparam int AGE_W = $clog2(RMW_MIN + 1);

  logic             row_fall, row_rise, wr_fall;
  logic [LANES-1:0] col_fall;
  phase_t           phase_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic             col_seen_q;
  logic [AGE_W-1:0] age_q;
  logic [LANES-1:0] lane_on_q, lane_on_d, rd_go, ew_go, rmw_ln;
  logic [REF_W-1:0] rfsh_cnt;
  logic all_col_hi, in_acc, auto_go, rej_go, acc_go, ronly_go;
  logic any_cf, wr_evt, rmw_go, ind_go;

  edo_pin_edges #(.LANES(LANES)) u_edges (
    .clk(clk), .rst(rst), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_n(wr_n), .row_fall(row_fall), .row_rise(row_rise),
    .col_fall(col_fall), .wr_fall(wr_fall)
  );

  edo_rfsh_ctr #(.W(REF_W)) u_ctr (
    .clk(clk), .rst(rst), .step(auto_go), .cnt(rfsh_cnt)
  );

  // Cycle classification from strobe ordering
  always_comb begin
    all_col_hi = &col_stb_n;
    in_acc     = (phase_q == PH_ACCESS);
    auto_go    = row_fall & ~all_col_hi & wr_n;
    rej_go     = row_fall & ~all_col_hi & ~wr_n;
    acc_go     = row_fall & all_col_hi;
    ronly_go   = row_rise & in_acc & ~col_seen_q;
    any_cf     = in_acc & (|col_fall);
    rd_go      = col_fall & {LANES{in_acc & wr_n}};
    ew_go      = col_fall & {LANES{in_acc & ~wr_n}};
    wr_evt     = in_acc & wr_fall & ~(|col_fall) & ~all_col_hi;
    rmw_go     = wr_evt & (age_q >= AGE_W'(RMW_MIN));
    ind_go     = wr_evt & ~rmw_go;
    rmw_ln     = ~col_stb_n & {LANES{rmw_go}};
    lane_on_d  = (lane_on_q | rd_go) & ~ew_go;
    if (wr_fall) lane_on_d = '0;
    if (row_stb_n && all_col_hi) lane_on_d = '0;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [MA_W-1:0] mem_adr;
    assign mem_adr = rmw_ln[l] ? {row_q, col_q} : {row_q, addr};
    edo_lane_store #(.AW(MA_W), .DW(LANE_W)) u_store (
      .clk(clk), .wen(ew_go[l] | rmw_ln[l]), .ren(rd_go[l]),
      .adr(mem_adr), .wdat(din[l*LANE_W +: LANE_W]),
      .rdat(dout[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      col_seen_q <= 1'b0;
      age_q      <= '0;
      lane_on_q  <= '0;
      dout_en    <= '0;
      rfsh_stb   <= 1'b0;
      rfsh_auto  <= 1'b0;
      rfsh_row   <= '0;
      wr_indet   <= 1'b0;
      seq_err    <= 1'b0;
    end else begin
      rfsh_stb <= auto_go | ronly_go;
      seq_err  <= rej_go;
      if (auto_go) begin
        rfsh_auto <= 1'b1;
        rfsh_row  <= rfsh_cnt;
      end else if (ronly_go) begin
        rfsh_auto <= 1'b0;
        rfsh_row  <= REF_W'(row_q);
      end

      if (row_fall)    wr_indet <= 1'b0;
      else if (ind_go) wr_indet <= 1'b1;

      if (row_fall) begin
        if (auto_go)     phase_q <= PH_REFRESH;
        else if (rej_go) phase_q <= PH_REJECT;
        else             phase_q <= PH_ACCESS;
      end else if (row_rise) begin
        phase_q <= PH_IDLE;
      end

      if (acc_go) begin
        row_q      <= addr;
        col_seen_q <= 1'b0;
      end
      if (any_cf) begin
        col_q      <= addr;
        col_seen_q <= 1'b1;
      end

      if (any_cf)                          age_q <= AGE_W'(1);
      else if (age_q < AGE_W'(RMW_MIN))    age_q <= age_q + 1'b1;

      lane_on_q <= lane_on_d;
      dout_en   <= lane_on_d & {LANES{~out_en_n}};
    end
  end
endmodule

// File: rtl/edo_dram_model_chk.sv
module edo_dram_model_chk #(
  parameter int LANES = 2,
  parameter int REF_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             row_stb_n,
  input logic             wr_n,
  input logic             out_en_n,
  input logic [LANES-1:0] dout_en,
  input logic             rfsh_stb,
  input logic             rfsh_auto,
  input logic [REF_W-1:0] rfsh_row,
  input logic             wr_indet,
  input logic             seq_err,
  input logic [REF_W-1:0] rfsh_cnt
);
  // R6: a counter refresh reports the value the counter held before stepping
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (rfsh_stb && rfsh_auto) |-> (rfsh_cnt == rfsh_row + 1'b1));

  // R11: a rejected ordering never refreshes or moves the counter
  assert_rej_no_rfsh_R11: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> !rfsh_stb);
  assert_rej_cnt_hold_R11: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> $stable(rfsh_cnt));

  // R9: no drive unless output enable was sampled low
  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (dout_en != '0) |-> !$past(out_en_n));

  // R8: a write strobe fall turns every lane off
  assert_wr_off_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |=> (dout_en == '0));

  // R5: the indeterminate flag only arises inside a row strobe low period
  assert_indet_in_row_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_indet) |-> !$past(row_stb_n));
endmodule

bind edo_dram_model edo_dram_model_chk #(.LANES(LANES), .REF_W(REF_W)) u_chk (.*);

// File: tb/sim_edo_dram_model.sv
module sim_edo_dram_model;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rs_n = 1'b1;
  logic [1:0]  cs_n = 2'b11;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b0;
  logic [3:0]  a = '0;
  logic [15:0] d = '0;
  logic [15:0] dout;
  logic [1:0]  dout_en;
  logic        rfsh_stb, rfsh_auto, wr_indet, seq_err;
  logic [8:0]  rfsh_row;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  edo_dram_model u0 (
    .clk(clk), .rst(rst), .row_stb_n(rs_n), .col_stb_n(cs_n), .wr_n(we_n),
    .out_en_n(oe_n), .addr(a), .din(d), .dout(dout), .dout_en(dout_en),
    .rfsh_stb(rfsh_stb), .rfsh_auto(rfsh_auto), .rfsh_row(rfsh_row),
    .wr_indet(wr_indet), .seq_err(seq_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference, evaluated at each rising edge
  logic [7:0] mm [0:1][0:255];
  logic [7:0] od [0:1];
  int   st, mrow, mcol, mage, mcnt, e_row;
  bit   mseen, prs, pwe, e_stb, e_auto, e_ind, e_err;
  bit [1:0] on, pcs, e_en;

  always @(posedge clk) begin
    bit rf, rr, wf, anyf;
    bit [1:0] cf;
    if (rst) begin
      st = 0; mrow = 0; mcol = 0; mage = 0; mcnt = 0; mseen = 0;
      prs = 1; pcs = 2'b11; pwe = 1; on = 0; e_en = 0;
      e_stb = 0; e_auto = 0; e_ind = 0; e_err = 0; e_row = 0;
    end else begin
      rf = prs && !rs_n; rr = !prs && rs_n; wf = pwe && !we_n; cf = pcs & ~cs_n;
      e_stb = 0; e_err = 0;
      anyf = (st == 1) && (cf != 0);
      if (st == 1) begin
        for (int l = 0; l < 2; l++) if (cf[l]) begin
          mcol = a; mseen = 1;
          if (!we_n) begin mm[l][mrow*16+mcol] = d[l*8 +: 8]; on[l] = 0; end
          else begin od[l] = mm[l][mrow*16+mcol]; on[l] = 1; end
        end
        if (wf && !anyf && cs_n != 2'b11) begin
          if (mage >= 2) begin
            for (int l = 0; l < 2; l++) if (!cs_n[l]) mm[l][mrow*16+mcol] = d[l*8 +: 8];
          end else e_ind = 1;
        end
      end
      if (anyf) mage = 1; else if (mage < 2) mage++;
      if (wf) on = 0;
      if (rs_n && cs_n == 2'b11) on = 0;
      if (rf) begin
        e_ind = 0;
        if (cs_n != 2'b11) begin
          if (we_n) begin e_stb = 1; e_auto = 1; e_row = mcnt; mcnt = (mcnt + 1) % 512; st = 2; end
          else begin e_err = 1; st = 3; end
        end else begin st = 1; mrow = a; mseen = 0; end
      end else if (rr) begin
        if (st == 1 && !mseen) begin e_stb = 1; e_auto = 0; e_row = mrow; end
        st = 0;
      end
      e_en = oe_n ? 2'b00 : on;
      prs = rs_n; pcs = cs_n; pwe = we_n;
    end
  end

  // Every-clock comparison with the reference
  always @(negedge clk) if (!rst) begin
    chk(dout_en === e_en, "R9", "dout_en vs model", dout_en, e_en);
    for (int l = 0; l < 2; l++)
      if (e_en[l]) chk(dout[l*8 +: 8] === od[l], "R2", "lane data vs model", dout[l*8 +: 8], od[l]);
    chk(rfsh_stb === e_stb, "R6", "rfsh_stb vs model", rfsh_stb, e_stb);
    if (e_stb) begin
      chk(rfsh_row === 9'(e_row), "R7", "rfsh_row vs model", rfsh_row, e_row);
      chk(rfsh_auto === e_auto, "R7", "rfsh_auto vs model", rfsh_auto, e_auto);
    end
    chk(wr_indet === e_ind, "R5", "wr_indet vs model", wr_indet, e_ind);
    chk(seq_err === e_err, "R11", "seq_err vs model", seq_err, e_err);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic ewrite(input logic [3:0] row, col, input logic [1:0] lanes, input logic [15:0] v);
    rs_n = 0; a = row; tick();
    a = col; we_n = 0; d = v; cs_n = ~lanes; tick();
    chk(dout_en === 2'b00, "R3", "early write drive", dout_en, 0);
    cs_n = 2'b11; we_n = 1; tick();
    rs_n = 1; tick();
  endtask

  task automatic read_chk(input logic [3:0] row, col, input logic [15:0] exp, input string tag);
    rs_n = 0; a = row; tick();
    a = col; we_n = 1; cs_n = 2'b00; tick();
    chk(dout_en === 2'b11, tag, "read enable", dout_en, 3);
    chk(dout === exp, tag, "read data", dout, exp);
    cs_n = 2'b11; tick();
    chk(dout_en === 2'b11, "R8", "hold after column rise", dout_en, 3);
    rs_n = 1; tick();
    chk(dout_en === 2'b00, "R8", "off with all strobes high", dout_en, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    chk(dout_en === 0 && rfsh_stb === 0, "R1", "reset outputs", {dout_en, rfsh_stb}, 0);
    chk(wr_indet === 0 && seq_err === 0, "R1", "reset flags", {wr_indet, seq_err}, 0);

    for (int i = 0; i < 513; i++) begin
      cs_n = 2'b00; tick();
      rs_n = 0; tick();
      chk(rfsh_stb === 1 && rfsh_auto === 1, "R6", "counter refresh strobe", {rfsh_stb, rfsh_auto}, 3);
      chk(rfsh_row === 9'(i % 512), "R6", "counter row and wrap", rfsh_row, i % 512);
      rs_n = 1; tick();
      cs_n = 2'b11; tick();
    end

    ewrite(4'd3, 4'd5, 2'b11, 16'hA55A);
    ewrite(4'd3, 4'd6, 2'b01, 16'h0011);
    ewrite(4'd3, 4'd6, 2'b10, 16'h2200);
    read_chk(4'd3, 4'd5, 16'hA55A, "R2");
    read_chk(4'd3, 4'd6, 16'h2211, "R3");

    // R12 page mode
    rs_n = 0; a = 4'd3; tick();
    a = 4'd5; cs_n = 2'b00; tick();
    chk(dout === 16'hA55A, "R12", "page first column", dout, 16'hA55A);
    cs_n = 2'b11; tick();
    a = 4'd6; cs_n = 2'b00; tick();
    chk(dout === 16'h2211, "R12", "page second column", dout, 16'h2211);
    cs_n = 2'b11; rs_n = 1; tick(); tick();

    // R9 output enable gate
    oe_n = 1; rs_n = 0; a = 4'd3; tick();
    a = 4'd5; cs_n = 2'b00; tick();
    chk(dout_en === 2'b00, "R9", "gated by output enable", dout_en, 0);
    oe_n = 0; tick();
    chk(dout_en === 2'b11, "R9", "released by output enable", dout_en, 3);
    cs_n = 2'b11; rs_n = 1; tick(); tick();

    // R4 read-modify-write
    ewrite(4'd7, 4'd2, 2'b11, 16'h1234);
    rs_n = 0; a = 4'd7; tick();
    a = 4'd2; cs_n = 2'b00; tick();
    chk(dout === 16'h1234, "R4", "old data before write", dout, 16'h1234);
    tick();
    we_n = 0; d = 16'hBEEF; tick();
    chk(dout_en === 2'b00, "R8", "write strobe turns off", dout_en, 0);
    chk(wr_indet === 0, "R4", "no indeterminate", wr_indet, 0);
    cs_n = 2'b11; we_n = 1; tick();
    rs_n = 1; tick();
    read_chk(4'd7, 4'd2, 16'hBEEF, "R4");

    // R5 indeterminate
    rs_n = 0; a = 4'd7; tick();
    a = 4'd2; cs_n = 2'b00; tick();
    we_n = 0; d = 16'h0000; tick();
    chk(wr_indet === 1, "R5", "indeterminate raised", wr_indet, 1);
    cs_n = 2'b11; we_n = 1; tick();
    rs_n = 1; tick();
    chk(wr_indet === 1, "R5", "indeterminate held", wr_indet, 1);
    read_chk(4'd7, 4'd2, 16'hBEEF, "R5");
    chk(wr_indet === 0, "R5", "cleared by next row fall", wr_indet, 0);

    // R7 row-only refresh
    rs_n = 0; a = 4'd9; tick();
    rs_n = 1; tick();
    chk(rfsh_stb === 1 && rfsh_auto === 0, "R7", "row-only strobe", {rfsh_stb, rfsh_auto}, 2);
    chk(rfsh_row === 9'd9, "R7", "row-only row", rfsh_row, 9);

    // R10 hidden refresh
    rs_n = 0; a = 4'd3; tick();
    a = 4'd5; cs_n = 2'b00; tick();
    rs_n = 1; tick();
    chk(dout_en === 2'b11, "R10", "drive across row rise", dout_en, 3);
    rs_n = 0; tick();
    chk(rfsh_stb === 1 && rfsh_auto === 1, "R10", "hidden refresh strobe", {rfsh_stb, rfsh_auto}, 3);
    chk(rfsh_row === 9'd1, "R10", "hidden refresh row", rfsh_row, 1);
    chk(dout_en === 2'b11 && dout === 16'hA55A, "R10", "data kept", dout, 16'hA55A);
    rs_n = 1; tick();
    cs_n = 2'b11; tick();
    chk(dout_en === 2'b00, "R8", "off after hidden refresh", dout_en, 0);

    // R11 ordering violation
    cs_n = 2'b00; we_n = 0; tick();
    rs_n = 0; tick();
    chk(seq_err === 1 && rfsh_stb === 0, "R11", "violation flagged", {seq_err, rfsh_stb}, 2);
    rs_n = 1; we_n = 1; tick();
    cs_n = 2'b11; tick();
    cs_n = 2'b00; tick();
    rs_n = 0; tick();
    chk(rfsh_row === 9'd2, "R11", "counter unchanged", rfsh_row, 2);
    rs_n = 1; tick();
    cs_n = 2'b11; tick(); tick();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule